// File: doc/BRIEF.md
# Configurable Lookup-Table Logic Cell

This block is one programmable cell of a logic fabric. A four-input lookup table, whose truth table is a 16-bit configuration mask, produces a combinational output. A single storage bit beside it can be set up as a D, toggle, J-K or set-reset flip-flop. Configuration inputs choose whether the cell's main output is the table output or the stored bit. They also choose the value the stored bit takes under device reset, and whether the stored bit replaces the fourth table input. A chain input and output let neighbouring cells be strung into a shift register that runs without the table.

The storage bit has a full control set. Device reset is the strongest control. Asynchronous clear comes next, then asynchronous load, which takes its data from the third table input; loading a one this way is how a preset is done. The clocked controls follow: clock enable gates synchronous clear, synchronous load and the mode-dependent update. The table output and the stored bit are both always visible, so the two halves of the cell can serve unrelated functions.

Top module: `cfg_logic_cell`

## Requirements
- R1: `lut_out` equals bit `cfg_mask[i]`, where i is the table address `{a3,a2,a1,a0}` = `{data_in[3],data_in[2],data_in[1],data_in[0]}` (address bit 3 replaced as in R10).
- R2: With `ena` high and no synchronous or asynchronous control active, a rising clock edge updates the stored bit by `cfg_mode`: 00 D (takes the source), 01 toggle (inverts when the source is 1), 10 J-K with J = `data_in[0]` and K = `data_in[1]` (00 hold, 10 set, 01 clear, 11 invert), 11 set-reset with S = `data_in[0]` and R = `data_in[1]` (10 set, 01 clear, 00 and 11 hold). The source is `lut_out` unless R11 applies.
- R3: While `aload` is high and `aclr` is low, the stored bit takes `data_in[2]` without waiting for a clock edge; with `data_in[2]` = 1 this presets the cell. A clock edge with `aload` high also loads `data_in[2]`.
- R4: `aclr` high clears the stored bit at once and wins over `aload`.
- R5: `dev_rst_n` low forces the stored bit to its power-up value at once, over every other control.
- R6: With `ena` low, clock edges leave the stored bit unchanged, even with `sclr` or `sload` high.
- R7: With `ena` high, `sclr` clears the stored bit at the clock edge and wins over `sload` and over the mode update.
- R8: With `ena` high and `sclr` low, `sload` loads `data_in[2]` at the clock edge in place of the mode update.
- R9: `cell_out` is the stored bit when `cfg_reg_out` is 1 and `lut_out` when it is 0; `lut_out` and `reg_out` are valid at the same time.
- R10: With `cfg_fb_en` high, table address bit 3 is the stored bit and `data_in[3]` is ignored.
- R11: With `cfg_chain_sel` high, the register source is `chain_in` instead of `lut_out`; `chain_out` always carries the stored bit.
- R12: The power-up value is 0 when `cfg_init_high` is 0 and 1 when it is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Cell clock, rising edge |
| dev_rst_n | input | 1 | Device-wide reset, active low, asynchronous |
| cfg_mask | input | 16 | Truth table of the lookup table |
| cfg_mode | input | 2 | Flip-flop mode: 00 D, 01 toggle, 10 J-K, 11 set-reset |
| cfg_reg_out | input | 1 | 1 selects the stored bit onto `cell_out` |
| cfg_init_high | input | 1 | Power-up value of the stored bit |
| cfg_fb_en | input | 1 | Route the stored bit into table address bit 3 |
| cfg_chain_sel | input | 1 | Register source from `chain_in` |
| data_in | input | 4 | Table inputs; bit 2 is also load data, bits 0 and 1 are J/S and K/R |
| ena | input | 1 | Clock enable |
| aclr | input | 1 | Asynchronous clear, active high |
| aload | input | 1 | Asynchronous load of `data_in[2]`, active high |
| sclr | input | 1 | Synchronous clear |
| sload | input | 1 | Synchronous load of `data_in[2]` |
| chain_in | input | 1 | Stored bit of the previous cell |
| lut_out | output | 1 | Combinational table output |
| reg_out | output | 1 | Stored bit |
| cell_out | output | 1 | Selected cell output |
| chain_out | output | 1 | Stored bit toward the next cell |

## Verification
The controls that collide are asynchronous clear and asynchronous load. Both are raised together with `data_in[2]` at 1, and a clock edge is let pass while both stay high; the stored bit must read 0 each time. Clear is then dropped with load still high, and the next edge must bring the one in. Synchronous clear and synchronous load are also raised in the same cycle, and the bench checks that the clear decides the result.

// File: rtl/cfg_logic_cell_pkg.sv
package cfg_logic_cell_pkg;

   typedef enum logic [1:0] {
      FF_D  = 2'b00,
      FF_T  = 2'b01,
      FF_JK = 2'b10,
      FF_SR = 2'b11
   } ff_mode_e;

endpackage

// File: rtl/cfg_logic_cell_lut.sv
module cfg_logic_cell_lut #(
   parameter int LUT_INPUTS = 4,
   parameter int FB_INDEX   = LUT_INPUTS - 1,
   localparam int MASK_W    = 1 << LUT_INPUTS
) (
   input  logic [MASK_W-1:0]     mask,
   input  logic [LUT_INPUTS-1:0] din,
   input  logic                  fb_en,
   input  logic                  fb_bit,
   output logic                  lut_o
);

   logic [LUT_INPUTS-1:0] addr;

   // Build the table address; one position may take the stored bit instead.
   for (genvar i = 0; i < LUT_INPUTS; i++) begin : g_addr
      if (i == FB_INDEX) begin : g_fb
         assign addr[i] = fb_en ? fb_bit : din[i];
      end else begin : g_plain
         assign addr[i] = din[i];
      end
   end

   assign lut_o = mask[addr];

endmodule

// File: rtl/cfg_logic_cell_next.sv
module cfg_logic_cell_next
   import cfg_logic_cell_pkg::*;
(
   input  ff_mode_e mode,
   input  logic     q,
   input  logic     src,
   input  logic     jset,
   input  logic     kclr,
   output logic     q_next
);

   always_comb begin
      unique case (mode)
         FF_D:  q_next = src;
         FF_T:  q_next = q ^ src;
         FF_JK: begin
            unique case ({jset, kclr})
               2'b10:   q_next = 1'b1;
               2'b01:   q_next = 1'b0;
               2'b11:   q_next = ~q;
               default: q_next = q;
            endcase
         end
         FF_SR: begin
            unique case ({jset, kclr})
               2'b10:   q_next = 1'b1;
               2'b01:   q_next = 1'b0;
               default: q_next = q;
            endcase
         end
         default: q_next = q;
      endcase
   end

endmodule

// File: rtl/cfg_logic_cell_ff.sv
module cfg_logic_cell_ff (
   input  logic clk,
   input  logic dev_rst_n,
   input  logic init_val,
   input  logic aclr,
   input  logic aload,
   input  logic adata,
   input  logic ena,
   input  logic sclr,
   input  logic sload,
   input  logic sdata,
   input  logic d_next,
   output logic q
);

   // Priority: device reset, async clear, async load, then enable-gated
   // synchronous clear, synchronous load, mode update.
   always_ff @(posedge clk or negedge dev_rst_n or posedge aclr or posedge aload) begin
      if (!dev_rst_n) begin
         q <= init_val;
      end else if (aclr) begin
         q <= 1'b0;
      end else if (aload) begin
         q <= adata;
      end else if (ena) begin
         if (sclr) begin
            q <= 1'b0;
         end else if (sload) begin
            q <= sdata;
         end else begin
            q <= d_next;
         end
      end
   end

endmodule

// File: rtl/cfg_logic_cell.sv
module cfg_logic_cell
   import cfg_logic_cell_pkg::*;
#(
   parameter int LUT_INPUTS  = 4,
   parameter int FB_INDEX    = LUT_INPUTS - 1,
   parameter int ADATA_INDEX = 2,
   parameter int J_INDEX     = 0,
   parameter int K_INDEX     = 1,
   localparam int MASK_W     = 1 << LUT_INPUTS
) (
   input  logic                  clk,
   input  logic                  dev_rst_n,
   input  logic [MASK_W-1:0]     cfg_mask,
   input  logic [1:0]            cfg_mode,
   input  logic                  cfg_reg_out,
   input  logic                  cfg_init_high,
   input  logic                  cfg_fb_en,
   input  logic                  cfg_chain_sel,
   input  logic [LUT_INPUTS-1:0] data_in,
   input  logic                  ena,
   input  logic                  aclr,
   input  logic                  aload,
   input  logic                  sclr,
   input  logic                  sload,
   input  logic                  chain_in,
   output logic                  lut_out,
   output logic                  reg_out,
   output logic                  cell_out,
   output logic                  chain_out
);

   if (LUT_INPUTS < 3 || LUT_INPUTS > 6) begin : g_bad_width
      $error("cfg_logic_cell: LUT_INPUTS must lie in 3..6");
   end
   if (FB_INDEX < 0 || FB_INDEX >= LUT_INPUTS) begin : g_bad_fb
      $error("cfg_logic_cell: FB_INDEX out of range");
   end
   if (ADATA_INDEX >= LUT_INPUTS || J_INDEX >= LUT_INPUTS || K_INDEX >= LUT_INPUTS) begin : g_bad_idx
      $error("cfg_logic_cell: control input index out of range");
   end
   if (J_INDEX == K_INDEX) begin : g_bad_jk
      $error("cfg_logic_cell: J and K must use distinct inputs");
   end

   logic q;
   logic q_next;
   logic src;

   cfg_logic_cell_lut #(
      .LUT_INPUTS (LUT_INPUTS),
      .FB_INDEX   (FB_INDEX)
   ) u_lut (
      .mask   (cfg_mask),
      .din    (data_in),
      .fb_en  (cfg_fb_en),
      .fb_bit (q),
      .lut_o  (lut_out)
   );

   assign src = cfg_chain_sel ? chain_in : lut_out;

   cfg_logic_cell_next u_next (
      .mode   (ff_mode_e'(cfg_mode)),
      .q      (q),
      .src    (src),
      .jset   (data_in[J_INDEX]),
      .kclr   (data_in[K_INDEX]),
      .q_next (q_next)
   );

   cfg_logic_cell_ff u_ff (
      .clk       (clk),
      .dev_rst_n (dev_rst_n),
      .init_val  (cfg_init_high),
      .aclr      (aclr),
      .aload     (aload),
      .adata     (data_in[ADATA_INDEX]),
      .ena       (ena),
      .sclr      (sclr),
      .sload     (sload),
      .sdata     (data_in[ADATA_INDEX]),
      .d_next    (q_next),
      .q         (q)
   );

   assign reg_out   = q;
   assign chain_out = q;
   assign cell_out  = cfg_reg_out ? q : lut_out;

endmodule

// File: rtl/cfg_logic_cell_chk.sv
module cfg_logic_cell_chk #(
   parameter int LUT_INPUTS = 4
) (
   input logic                  clk,
   input logic                  dev_rst_n,
   input logic [1:0]            cfg_mode,
   input logic                  cfg_chain_sel,
   input logic [LUT_INPUTS-1:0] data_in,
   input logic                  ena,
   input logic                  aclr,
   input logic                  aload,
   input logic                  sclr,
   input logic                  sload,
   input logic                  chain_in,
   input logic                  lut_out,
   input logic                  reg_out
);

   a_r4_aclr_holds_zero: assert property (@(posedge clk) disable iff (!dev_rst_n)
      aclr |-> !reg_out);

   a_r3_aload_tracks_data: assert property (@(posedge clk) disable iff (!dev_rst_n)
      (aload && !aclr && $past(aload) && $past(!aclr) && $past(dev_rst_n)
       && $stable(data_in[2])) |-> (reg_out == data_in[2]));

   a_r6_enable_low_freezes: assert property (@(posedge clk) disable iff (!dev_rst_n)
      (!ena && !aclr && !aload) |=> (aclr || aload || reg_out == $past(reg_out)));

   a_r7_sclr_wins: assert property (@(posedge clk) disable iff (!dev_rst_n)
      (ena && sclr && !aclr && !aload) |=> (aclr || aload || !reg_out));

   a_r2_d_mode_captures_lut: assert property (@(posedge clk) disable iff (!dev_rst_n)
      (ena && !sclr && !sload && !aclr && !aload && cfg_mode == 2'b00 && !cfg_chain_sel)
      |=> (aclr || aload || reg_out == $past(lut_out)));

   a_r11_chain_capture: assert property (@(posedge clk) disable iff (!dev_rst_n)
      (ena && !sclr && !sload && !aclr && !aload && cfg_mode == 2'b00 && cfg_chain_sel)
      |=> (aclr || aload || reg_out == $past(chain_in)));

endmodule

bind cfg_logic_cell cfg_logic_cell_chk #(
   .LUT_INPUTS (LUT_INPUTS)
) u_chk (
   .clk           (clk),
   .dev_rst_n     (dev_rst_n),
   .cfg_mode      (cfg_mode),
   .cfg_chain_sel (cfg_chain_sel),
   .data_in       (data_in),
   .ena           (ena),
   .aclr          (aclr),
   .aload         (aload),
   .sclr          (sclr),
   .sload         (sload),
   .chain_in      (chain_in),
   .lut_out       (lut_out),
   .reg_out       (reg_out)
);

// File: tb/cfg_logic_cell_tb.sv
module cfg_logic_cell_tb;

   logic        clk = 1'b0;
   logic        dev_rst_n = 1'b0;
   logic [15:0] cfg_mask = '0;
   logic [1:0]  cfg_mode = 2'b00;
   logic        cfg_reg_out = 1'b0;
   logic        cfg_init_high = 1'b0;
   logic        cfg_fb_en = 1'b0;
   logic        cfg_chain_sel = 1'b0;
   logic [3:0]  data_in = '0;
   logic        ena = 1'b0;
   logic        aclr = 1'b0;
   logic        aload = 1'b0;
   logic        sclr = 1'b0;
   logic        sload = 1'b0;
   logic        chain_in = 1'b0;
   logic        lut_out, reg_out, cell_out, chain_out;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   cfg_logic_cell u_dut (
      .clk           (clk),
      .dev_rst_n     (dev_rst_n),
      .cfg_mask      (cfg_mask),
      .cfg_mode      (cfg_mode),
      .cfg_reg_out   (cfg_reg_out),
      .cfg_init_high (cfg_init_high),
      .cfg_fb_en     (cfg_fb_en),
      .cfg_chain_sel (cfg_chain_sel),
      .data_in       (data_in),
      .ena           (ena),
      .aclr          (aclr),
      .aload         (aload),
      .sclr          (sclr),
      .sload         (sload),
      .chain_in      (chain_in),
      .lut_out       (lut_out),
      .reg_out       (reg_out),
      .cell_out      (cell_out),
      .chain_out     (chain_out)
   );

   task automatic chk(input string req, input logic act, input logic exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic t_reset();
      repeat (2) tick();
      chk("R5 reset state", reg_out, 1'b0);
      cfg_init_high = 1'b1;
      tick();
      chk("R12 power-up high", reg_out, 1'b1);
      cfg_init_high = 1'b0;
      tick();
      chk("R12 power-up low", reg_out, 1'b0);
      dev_rst_n = 1'b1;
      tick();
   endtask

   task automatic t_lut();
      logic [15:0] m = 16'hA5C3;
      cfg_mask = m;
      cfg_reg_out = 1'b0;
      for (int i = 0; i < 16; i++) begin
         data_in = 4'(i);
         #1;
         chk("R1 table lookup", lut_out, m[i]);
         if (i == 5) chk("R9 combinational select", cell_out, m[i]);
      end
   endtask

   task automatic t_dmode();
      cfg_mode = 2'b00; ena = 1'b1;
      cfg_mask = 16'h8000; data_in = 4'hF;
      tick();
      chk("R2 D capture one", reg_out, 1'b1);
      data_in = 4'h0; cfg_reg_out = 1'b1;
      #1;
      chk("R9 lut_out independent", lut_out, 1'b0);
      chk("R9 registered select", cell_out, 1'b1);
      tick();
      chk("R2 D capture zero", reg_out, 1'b0);
      chk("R9 registered follows", cell_out, 1'b0);
   endtask

   task automatic t_tmode();
      cfg_mode = 2'b01; cfg_mask = 16'hFFFF;
      tick();
      chk("R2 toggle up", reg_out, 1'b1);
      tick();
      chk("R2 toggle down", reg_out, 1'b0);
      cfg_mask = 16'h0000;
      tick();
      chk("R2 toggle hold", reg_out, 1'b0);
   endtask

   task automatic t_jk();
      cfg_mode = 2'b10;
      data_in = 4'b0001; tick(); chk("R2 JK set", reg_out, 1'b1);
      data_in = 4'b0000; tick(); chk("R2 JK hold", reg_out, 1'b1);
      data_in = 4'b0011; tick(); chk("R2 JK invert a", reg_out, 1'b0);
      tick();                    chk("R2 JK invert b", reg_out, 1'b1);
      data_in = 4'b0010; tick(); chk("R2 JK clear", reg_out, 1'b0);
   endtask

   task automatic t_sr();
      cfg_mode = 2'b11;
      data_in = 4'b0001; tick(); chk("R2 SR set", reg_out, 1'b1);
      data_in = 4'b0011; tick(); chk("R2 SR both hold one", reg_out, 1'b1);
      data_in = 4'b0010; tick(); chk("R2 SR reset", reg_out, 1'b0);
      data_in = 4'b0011; tick(); chk("R2 SR both hold zero", reg_out, 1'b0);
   endtask

   task automatic t_enable();
      cfg_mode = 2'b00; cfg_mask = 16'hFFFF; data_in = 4'h0;
      tick();
      chk("R2 D set before freeze", reg_out, 1'b1);
      ena = 1'b0; cfg_mask = 16'h0000; sclr = 1'b1;
      tick();
      chk("R6 frozen against sclr", reg_out, 1'b1);
      sclr = 1'b0; sload = 1'b1; data_in = 4'b0000;
      tick();
      chk("R6 frozen against sload", reg_out, 1'b1);
      sload = 1'b0;
   endtask

   task automatic t_sync();
      ena = 1'b1; cfg_mask = 16'h0000;
      tick();
      chk("R2 D clear before sync", reg_out, 1'b0);
      sload = 1'b1; data_in = 4'b0100;
      tick();
      chk("R8 sync load one", reg_out, 1'b1);
      sclr = 1'b1;
      tick();
      chk("R7 sclr beats sload", reg_out, 1'b0);
      sclr = 1'b0; sload = 1'b0; cfg_mask = 16'hFFFF;
      tick();
      chk("R2 mode resumes", reg_out, 1'b1);
      sclr = 1'b1;
      tick();
      chk("R7 sclr beats mode", reg_out, 1'b0);
      sclr = 1'b0;
   endtask

   task automatic t_async();
      ena = 1'b0; cfg_mode = 2'b00;
      data_in = 4'b0100; aload = 1'b1;
      #1;
      chk("R3 async preset", reg_out, 1'b1);
      aload = 1'b0; #1;
      data_in = 4'b0000; #1;
      aload = 1'b1; #1;
      chk("R3 async load zero", reg_out, 1'b0);
      aload = 1'b0; #1;
      @(negedge clk);
      data_in = 4'b0100; aload = 1'b1;
      #1;
      chk("R3 async preset again", reg_out, 1'b1);
      aclr = 1'b1;
      #1;
      chk("R4 clear over load", reg_out, 1'b0);
      tick();
      chk("R4 clear holds at edge", reg_out, 1'b0);
      aclr = 1'b0;
      tick();
      chk("R3 load at clock edge", reg_out, 1'b1);
   endtask

   task automatic t_devrst();
      // aload still high with data_in[2] = 1
      dev_rst_n = 1'b0;
      #1;
      chk("R5 reset over load", reg_out, 1'b0);
      aclr = 1'b1; ena = 1'b1; cfg_mask = 16'hFFFF;
      tick();
      chk("R5 reset holds at edge", reg_out, 1'b0);
      aclr = 1'b0; aload = 1'b0; data_in = 4'h0;
      dev_rst_n = 1'b1;
      cfg_mask = 16'h0000;
      tick();
   endtask

   task automatic t_feedback();
      cfg_mode = 2'b00; ena = 1'b1; cfg_fb_en = 1'b1;
      cfg_mask = 16'h00FF; data_in = 4'b1000;
      #1;
      chk("R10 feedback addr zero", lut_out, 1'b1);
      tick();
      chk("R10 feedback capture", reg_out, 1'b1);
      #1;
      chk("R10 feedback addr eight", lut_out, 1'b0);
      tick();
      chk("R10 feedback toggles back", reg_out, 1'b0);
      cfg_fb_en = 1'b0;
      #1;
      chk("R10 data_in[3] used when off", lut_out, 1'b0);
      data_in = 4'b0000;
      #1;
      chk("R1 address bit3 clear", lut_out, 1'b1);
   endtask

   task automatic t_chain();
      @(negedge clk);
      cfg_chain_sel = 1'b1; cfg_mask = 16'h0000; chain_in = 1'b1;
      tick();
      chk("R11 chain capture", reg_out, 1'b1);
      chk("R11 chain_out", chain_out, 1'b1);
      chain_in = 1'b0; cfg_mask = 16'hFFFF;
      tick();
      chk("R11 chain over lut", reg_out, 1'b0);
      cfg_mode = 2'b01; chain_in = 1'b1;
      tick();
      chk("R11 chain toggle", chain_out, 1'b1);
      cfg_chain_sel = 1'b0;
   endtask

   initial begin
      t_reset();
      t_lut();
      t_dmode();
      t_tmode();
      t_jk();
      t_sr();
      t_enable();
      t_sync();
      t_async();
      t_devrst();
      t_feedback();
      t_chain();
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

endmodule